// File: doc/BRIEF.md
# Framed Serial Control Register Loader

This block loads configuration registers from a single-wire serial stream. A companion word-rate strobe paces the stream, and the block reads one bit on each falling edge of that strobe. When the line is idle it sits high. A frame opens with a low start bit. Twelve data bits follow, most significant first, and then a three-bit register ID, also most significant first. A frame is written into its register only after the line has stayed high for a run of at least sixteen strobe periods.

The bank holds eight register IDs. IDs 0 to 5 carry configuration and their fields are decoded onto output ports: receive gain, external gain pins, transmit attenuation, general-purpose outputs, the sign-format select, the word-clock divider, the loopback and latch-edge selects, and the oscillator DAC code. IDs 6 and 7 are reserved. A frame addressed to either of them is accepted and changes nothing. Every accepted frame produces a one-cycle commit strobe together with its ID. All other logic continues to run while a frame is arriving.

Top module: `ctrl_frame_loader`

## Requirements
- R1: After reset every decoded field reads zero and commit_stb is low.
- R2: ctrl_sdi is read only in a clock cycle whose edge sees word_strb go from high to low. Values that ctrl_sdi holds at any other edge have no effect.
- R3: A frame is a low start bit, then data bits 11 down to 0, then ID bits 2 down to 0. While the loader is idle, high bits are ignored.
- R4: A frame is committed on its 16th consecutive high stop bit. With only 15 stop bits and no further strobe edge, nothing is committed. A pause in the strobe does not break the run of stop bits.
- R5: A low bit that arrives before the 16th stop bit discards the pending frame and acts as the start bit of a new frame.
- R6: commit_stb is high for exactly one cycle, in the second clock cycle after the edge that read the 16th stop bit. commit_id gives the frame's ID, and the register values are already updated in that cycle.
- R7: A frame to ID 6 or 7 raises commit_stb with its ID and leaves every output field unchanged.
- R8: ID 0 maps bits [5:0] to rx_gain, bits [7:6] to gain_pins and bit 8 to rx_narrow.
- R9: ID 1 maps bits [4:0] to tx_atten (one step per dB of attenuation), bits [7:5] to gpo and bit 8 to one_sign.
- R10: ID 2 maps bit 0 to dig_loop, bit 1 to ana_loop, bit 2 to rx_en and bits [4:3] to word_div.
- R11: ID 3 maps bits [9:0] to osc_dac. ID 4 maps bit 0 to tx_rise, bit 1 to rx_rise and bit 2 to rx2tx_loop. ID 5 appears whole on aux_cfg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_strb | input | 1 | Word-rate strobe; each falling edge reads one bit |
| ctrl_sdi | input | 1 | Serial control data, idle high |
| rx_gain | output | 6 | Receive gain code |
| gain_pins | output | 2 | External gain control outputs |
| rx_narrow | output | 1 | Receive filter select |
| tx_atten | output | 5 | Transmit attenuation code |
| gpo | output | 3 | General-purpose outputs |
| one_sign | output | 1 | 1 = one sign bit, 0 = two sign bits |
| dig_loop | output | 1 | Digital loopback enable |
| ana_loop | output | 1 | Analog loopback enable |
| rx_en | output | 1 | Receive enable |
| word_div | output | 2 | Word-clock divider select |
| osc_dac | output | 10 | Oscillator DAC code |
| tx_rise | output | 1 | Transmit nibble latch edge select |
| rx_rise | output | 1 | Receive nibble latch edge select |
| rx2tx_loop | output | 1 | Receive-to-transmit loopback |
| aux_cfg | output | 12 | Raw contents of register ID 5 |
| commit_stb | output | 1 | One-cycle pulse per accepted frame |
| commit_id | output | 3 | ID of the accepted frame |

## Verification
The bench uses the default parameters: 12 data bits, a 3-bit ID and a 16-bit stop run. With these values every ID, including both reserved ones, and the exact stop-run threshold can be reached with short frames. The 15-stop and 16-stop boundaries, aborts at several stop counts, and the restart from an aborted frame are all directly testable. Random frames alternate with aborted frames, and garbage on the data line between strobe edges tests that only the falling edge reads data.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_STOP = 2'd2
  } rx_state_e;

  // register IDs carrying decoded configuration
  localparam int ID_RX   = 0;
  localparam int ID_TX   = 1;
  localparam int ID_MODE = 2;
  localparam int ID_DAC  = 3;
  localparam int ID_IFC  = 4;
  localparam int ID_AUX  = 5;
  localparam int NUM_FUNC_IDS = 6;

  // field widths
  localparam int GAIN_W  = 6;
  localparam int GPIN_W  = 2;
  localparam int ATTEN_W = 5;
  localparam int GPO_W   = 3;
  localparam int DIV_W   = 2;
  localparam int DAC_W   = 10;

endpackage

// File: rtl/cfl_rst_sync.sv
module cfl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/cfl_strobe_edge.sv
module cfl_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strb,
  input  logic din,
  output logic bit_tick,
  output logic bit_val
);

  logic strb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= 1'b0;
    else        strb_q <= strb;
  end

  assign bit_tick = strb_q & ~strb;
  assign bit_val  = din;

  // R2: a falling edge cannot be seen on two edges in a row
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

endmodule

// File: rtl/cfl_frame_rx.sv
module cfl_frame_rx
  import cfl_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int ID_W      = 3,
  parameter int STOP_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              bit_val,
  output logic              wr_en,
  output logic [ID_W-1:0]   wr_id,
  output logic [DATA_W-1:0] wr_data
);

  localparam int BODY_W = DATA_W + ID_W;
  localparam int CNT_W  = $clog2(BODY_W + 1);
  localparam int STP_W  = $clog2(STOP_BITS + 1);
  localparam logic [CNT_W-1:0] BODY_LAST = CNT_W'(BODY_W - 1);
  localparam logic [STP_W-1:0] STOP_LAST = STP_W'(STOP_BITS - 1);

  rx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [STP_W-1:0]   stp_q, stp_d;
  logic [BODY_W-1:0]  sh_q, sh_d;
  logic               wr_en_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    stp_d   = stp_q;
    sh_d    = sh_q;
    wr_en_d = 1'b0;
    if (bit_tick) begin
      case (state_q)
        ST_IDLE: begin
          if (!bit_val) begin
            state_d = ST_BODY;
            cnt_d   = '0;
          end
        end
        ST_BODY: begin
          sh_d = {sh_q[BODY_W-2:0], bit_val};
          if (cnt_q == BODY_LAST) begin
            state_d = ST_STOP;
            stp_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (bit_val) begin
            if (stp_q == STOP_LAST) begin
              wr_en_d = 1'b1;
              state_d = ST_IDLE;
            end else begin
              stp_d = stp_q + 1'b1;
            end
          end else begin
            // early low: pending frame dropped, this bit starts a new one
            state_d = ST_BODY;
            cnt_d   = '0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      stp_q   <= '0;
      sh_q    <= '0;
      wr_en   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      stp_q   <= stp_d;
      sh_q    <= sh_d;
      wr_en   <= wr_en_d;
    end
  end

  assign wr_data = sh_q[BODY_W-1:ID_W];
  assign wr_id   = sh_q[ID_W-1:0];

  // checker-only run length of consecutive high bits, saturating
  logic [STP_W-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else if (bit_tick) begin
      if (!bit_val)                           hi_run <= '0;
      else if (hi_run != STP_W'(STOP_BITS))   hi_run <= hi_run + 1'b1;
    end
  end

  // R4: a write only follows a full run of high stop bits
  a_r4_stop_run: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (hi_run == STP_W'(STOP_BITS)));

  // R2: nothing in the receiver moves without a strobe edge
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable({state_q, cnt_q, stp_q, sh_q}));

  // R6: the write request lasts one cycle
  a_r6_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

endmodule

// File: rtl/cfl_cfg_bank.sv
module cfl_cfg_bank #(
  parameter int DATA_W = 12,
  parameter int ID_W   = 3,
  parameter int NFUNC  = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ID_W-1:0]              wr_id,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NFUNC-1:0][DATA_W-1:0] regs_o,
  output logic                         commit_stb,
  output logic [ID_W-1:0]              commit_id
);

  for (genvar g = 0; g < NFUNC; g++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    logic              hit;
    assign hit = wr_en && (wr_id == ID_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   r_q <= '0;
      else if (hit) r_q <= wr_data;
    end
    assign regs_o[g] = r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_stb <= 1'b0;
      commit_id  <= '0;
    end else begin
      commit_stb <= wr_en;
      if (wr_en) commit_id <= wr_id;
    end
  end

  // R7: reserved IDs leave the bank untouched
  a_r7_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_id >= ID_W'(NFUNC))) |=> $stable(regs_o));

  // R6: one strobe per commit
  a_r6_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |=> !commit_stb);

endmodule

// File: rtl/ctrl_frame_loader.sv
module ctrl_frame_loader
  import cfl_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int ID_W      = 3,
  parameter int STOP_BITS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_strb,
  input  logic               ctrl_sdi,
  output logic [GAIN_W-1:0]  rx_gain,
  output logic [GPIN_W-1:0]  gain_pins,
  output logic               rx_narrow,
  output logic [ATTEN_W-1:0] tx_atten,
  output logic [GPO_W-1:0]   gpo,
  output logic               one_sign,
  output logic               dig_loop,
  output logic               ana_loop,
  output logic               rx_en,
  output logic [DIV_W-1:0]   word_div,
  output logic [DAC_W-1:0]   osc_dac,
  output logic               tx_rise,
  output logic               rx_rise,
  output logic               rx2tx_loop,
  output logic [DATA_W-1:0]  aux_cfg,
  output logic               commit_stb,
  output logic [ID_W-1:0]    commit_id
);

  logic                                rst_n_s;
  logic                                bit_tick, bit_val;
  logic                                wr_en;
  logic [ID_W-1:0]                     wr_id;
  logic [DATA_W-1:0]                   wr_data;
  logic [NUM_FUNC_IDS-1:0][DATA_W-1:0] regs;

  cfl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  cfl_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n_s), .strb(word_strb), .din(ctrl_sdi),
    .bit_tick(bit_tick), .bit_val(bit_val)
  );

  cfl_frame_rx #(.DATA_W(DATA_W), .ID_W(ID_W), .STOP_BITS(STOP_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .bit_tick(bit_tick), .bit_val(bit_val),
    .wr_en(wr_en), .wr_id(wr_id), .wr_data(wr_data)
  );

  cfl_cfg_bank #(.DATA_W(DATA_W), .ID_W(ID_W), .NFUNC(NUM_FUNC_IDS)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_id(wr_id),
    .wr_data(wr_data), .regs_o(regs), .commit_stb(commit_stb),
    .commit_id(commit_id)
  );

  // field decode
  assign rx_gain    = regs[ID_RX][GAIN_W-1:0];
  assign gain_pins  = regs[ID_RX][GAIN_W+GPIN_W-1:GAIN_W];
  assign rx_narrow  = regs[ID_RX][8];
  assign tx_atten   = regs[ID_TX][ATTEN_W-1:0];
  assign gpo        = regs[ID_TX][ATTEN_W+GPO_W-1:ATTEN_W];
  assign one_sign   = regs[ID_TX][8];
  assign dig_loop   = regs[ID_MODE][0];
  assign ana_loop   = regs[ID_MODE][1];
  assign rx_en      = regs[ID_MODE][2];
  assign word_div   = regs[ID_MODE][3+DIV_W-1:3];
  assign osc_dac    = regs[ID_DAC][DAC_W-1:0];
  assign tx_rise    = regs[ID_IFC][0];
  assign rx_rise    = regs[ID_IFC][1];
  assign rx2tx_loop = regs[ID_IFC][2];
  assign aux_cfg    = regs[ID_AUX];

  logic unused_bits;
  assign unused_bits = ^{regs[ID_RX][DATA_W-1:9], regs[ID_TX][DATA_W-1:9],
                         regs[ID_MODE][DATA_W-1:5], regs[ID_DAC][DATA_W-1:DAC_W],
                         regs[ID_IFC][DATA_W-1:3]};

endmodule

// File: tb/sim_ctrl_frame_loader.sv
module sim_ctrl_frame_loader;

  logic clk = 1'b0;
  logic rst_n, word_strb, ctrl_sdi;
  logic [5:0] rx_gain; logic [1:0] gain_pins; logic rx_narrow;
  logic [4:0] tx_atten; logic [2:0] gpo; logic one_sign;
  logic dig_loop, ana_loop, rx_en; logic [1:0] word_div;
  logic [9:0] osc_dac; logic tx_rise, rx_rise, rx2tx_loop;
  logic [11:0] aux_cfg; logic commit_stb; logic [2:0] commit_id;

  always #10 clk = ~clk;

  ctrl_frame_loader u0 (
    .clk(clk), .rst_n(rst_n), .word_strb(word_strb), .ctrl_sdi(ctrl_sdi),
    .rx_gain(rx_gain), .gain_pins(gain_pins), .rx_narrow(rx_narrow),
    .tx_atten(tx_atten), .gpo(gpo), .one_sign(one_sign),
    .dig_loop(dig_loop), .ana_loop(ana_loop), .rx_en(rx_en),
    .word_div(word_div), .osc_dac(osc_dac), .tx_rise(tx_rise),
    .rx_rise(rx_rise), .rx2tx_loop(rx2tx_loop), .aux_cfg(aux_cfg),
    .commit_stb(commit_stb), .commit_id(commit_id)
  );

  int nchk = 0, nerr = 0, ncommit = 0;
  logic [11:0] mdl [6];

  always @(negedge clk) if (rst_n && commit_stb) ncommit++;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_fields();
    chk("R8 rx_gain",     int'(rx_gain),    int'(mdl[0][5:0]));
    chk("R8 gain_pins",   int'(gain_pins),  int'(mdl[0][7:6]));
    chk("R8 rx_narrow",   int'(rx_narrow),  int'(mdl[0][8]));
    chk("R9 tx_atten",    int'(tx_atten),   int'(mdl[1][4:0]));
    chk("R9 gpo",         int'(gpo),        int'(mdl[1][7:5]));
    chk("R9 one_sign",    int'(one_sign),   int'(mdl[1][8]));
    chk("R10 dig_loop",   int'(dig_loop),   int'(mdl[2][0]));
    chk("R10 ana_loop",   int'(ana_loop),   int'(mdl[2][1]));
    chk("R10 rx_en",      int'(rx_en),      int'(mdl[2][2]));
    chk("R10 word_div",   int'(word_div),   int'(mdl[2][4:3]));
    chk("R11 osc_dac",    int'(osc_dac),    int'(mdl[3][9:0]));
    chk("R11 tx_rise",    int'(tx_rise),    int'(mdl[4][0]));
    chk("R11 rx_rise",    int'(rx_rise),    int'(mdl[4][1]));
    chk("R11 rx2tx_loop", int'(rx2tx_loop), int'(mdl[4][2]));
    chk("R11 aux_cfg",    int'(aux_cfg),    int'(mdl[5]));
  endtask

  // one bit period: garbage at the rising-strobe edge (R2), value at the fall
  task automatic send_bit(input logic b);
    @(negedge clk); word_strb = 1'b1; ctrl_sdi = ~b;
    @(negedge clk); word_strb = 1'b0; ctrl_sdi = b;
  endtask

  task automatic send_body(input logic [2:0] id, input logic [11:0] data);
    send_bit(1'b0);
    for (int i = 11; i >= 0; i--) send_bit(data[i]);
    for (int i = 2; i >= 0; i--) send_bit(id[i]);
  endtask

  task automatic send_stops(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  // frame with exactly 16 stops, exact strobe timing checked (R6)
  task automatic frame_checked(input logic [2:0] id, input logic [11:0] data);
    int c0;
    c0 = ncommit;
    send_body(id, data);
    send_stops(16);
    @(negedge clk);
    chk("R6 no early commit", int'(commit_stb), 0);
    @(negedge clk);
    chk("R6 commit strobe", int'(commit_stb), 1);
    chk("R6 commit id", int'(commit_id), int'(id));
    if (id < 3'd6) mdl[id] = data;
    check_fields();
    @(negedge clk);
    chk("R6 strobe one cycle", int'(commit_stb), 0);
    chk("R6 single commit", ncommit - c0, 1);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 6; i++) mdl[i] = '0;
    rst_n = 1'b0; word_strb = 1'b0; ctrl_sdi = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 commit_stb", int'(commit_stb), 0);
    check_fields();

    // R3 idle highs do nothing
    send_stops(20);
    repeat (3) @(negedge clk);
    chk("R3 idle no commit", ncommit, 0);

    // directed field patterns, R3 bit order via asymmetric data
    frame_checked(3'd0, 12'h1A5);
    frame_checked(3'd1, 12'h1F3);
    frame_checked(3'd2, 12'h01B);
    frame_checked(3'd3, 12'h2C7);
    frame_checked(3'd4, 12'h005);
    frame_checked(3'd5, 12'hA3C);

    // R7 reserved IDs: strobe, no field change
    frame_checked(3'd6, 12'hFFF);
    frame_checked(3'd7, 12'h555);

    // R4 boundary: 15 stops then a strobe pause, then the 16th
    c0 = ncommit;
    send_body(3'd2, 12'h014);
    send_stops(15);
    repeat (10) @(negedge clk);
    chk("R4 fifteen stops no commit", ncommit - c0, 0);
    check_fields();
    send_bit(1'b1);
    @(negedge clk);
    @(negedge clk);
    chk("R4 sixteenth stop commits", int'(commit_stb), 1);
    mdl[2] = 12'h014;
    @(negedge clk);
    check_fields();

    // R5 abort after 7 stops; the low bit starts the next frame
    c0 = ncommit;
    send_body(3'd3, 12'h3FF);
    send_stops(7);
    frame_checked(3'd3, 12'h0A1);
    chk("R5 aborted frame dropped", ncommit - c0, 1);

    // R5 abort after 15 stops, and with no stops at all
    c0 = ncommit;
    send_body(3'd0, 12'h0FF);
    send_stops(15);
    send_body(3'd5, 12'h777);
    frame_checked(3'd1, 12'h0E2);
    chk("R5 two aborts dropped", ncommit - c0, 1);

    // random frames mixed with aborts
    for (int n = 0; n < 60; n++) begin
      logic [2:0] id;
      logic [11:0] dat;
      if ($urandom % 4 == 0) begin
        c0 = ncommit;
        send_body(3'($urandom), 12'($urandom));
        send_stops(int'($urandom % 16));
        id = 3'($urandom); dat = 12'($urandom);
        frame_checked(id, dat);
        chk("R5 random abort", ncommit - c0, 1);
      end else begin
        id = 3'($urandom); dat = 12'($urandom);
        frame_checked(id, dat);
      end
      send_stops(int'($urandom % 5));
    end

    repeat (3) @(negedge clk);
    check_fields();
    finish_run();
  end

endmodule